// File: doc/BRIEF.md
# Front-End Resynchronization Buffer Controller

This block sits between the compression stage of a detector front-end and the frame packer that feeds the serial link. Every clock cycle is one bunch crossing. The block keeps its own crossing counter. On each crossing it stores one entry in an event FIFO. The entry holds the crossing identifier, a length field and a payload word, and it is stored in arrival order. A crossing that carries a veto or header-only command is kept as a bare header. So is a crossing with no upstream data, or one that arrives while the buffer is near its limit.

Two fast commands reset the readout without software. A synch command empties the FIFO at one clock edge and leaves the crossing counter running. For each cycle the synch command is held, the block presents one pattern frame that carries that cycle's crossing identifier, so the receiver learns which crossing comes next. The first event after the sequence is flagged so the packer starts it on bit 0 of a new frame. A front-end reset empties the FIFO in the same way and also reloads the crossing counter, but it produces no pattern frame.

The packer reads the FIFO head directly (show-ahead) and pops it with a ready strobe. A pattern frame is shown for exactly one cycle and is not popped.

Top module: `fe_sync_buffer_ctrl`

## Requirements
- R1: While reset is asserted, out_valid, buf_fill, buf_full and buf_overflow are all 0.
- R2: Each crossing with neither cmd_synch nor cmd_fe_reset stores one entry tagged with the current crossing ID, and entries leave in arrival order. The crossing counter advances once per cycle and wraps from BX_LAST (default 3563) to 0.
- R3: An entry keeps ev_len and ev_data only if ev_valid is 1, neither cmd_bx_veto nor cmd_hdr_only is set (the two have the same effect), and the buffer is not in full mode. Otherwise its length and payload are 0.
- R4: Outside a pattern frame, out_valid is 1 exactly when the FIFO holds an entry, out_kind is 0, and the head fields are shown. The head is removed at a clock edge where out_ready is 1, and it stays unchanged while out_ready is 0.
- R5: buf_fill gives the number of stored entries (0 to DEPTH). buf_full is 1 when buf_fill is at least DEPTH-HDR_RESERVE (default 240). A crossing that arrives with buf_fill equal to DEPTH is dropped.
- R6: cmd_synch empties the FIFO at one edge (buf_fill is 0 the next cycle) and does not disturb the crossing counter.
- R7: For every cycle with cmd_synch set (and cmd_fe_reset clear), the next cycle shows one pattern frame: out_valid 1, out_kind 1, out_bxid equal to that cycle's crossing ID, out_len 0, and out_data equal to SYNC_WORD. out_ready has no effect on it.
- R8: out_new_frame is 1 while the first data entry after a synch or a front-end reset is at the head, and it is 0 otherwise.
- R9: cmd_fe_reset empties the FIFO, clears buf_overflow and produces no pattern frame. The crossing that follows gets ID BX_RELOAD (default 16). It takes priority over cmd_synch.
- R10: buf_overflow is set when a data crossing is cut back to a header because of full mode, or when a crossing is dropped. It stays set until cmd_synch or cmd_fe_reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_synch | input | 1 | Synch command for this crossing |
| cmd_fe_reset | input | 1 | Front-end reset command for this crossing |
| cmd_bx_veto | input | 1 | Crossing veto, keep header only |
| cmd_hdr_only | input | 1 | Header-only command |
| ev_valid | input | 1 | Upstream data present for this crossing |
| ev_len | input | LEN_W | Upstream event length |
| ev_data | input | DATA_W | Upstream payload word |
| out_ready | input | 1 | Packer pops the head entry |
| out_valid | output | 1 | Head entry or pattern frame present |
| out_kind | output | 1 | 0 = data entry, 1 = pattern frame |
| out_bxid | output | BXID_W | Crossing ID of the head entry or pattern |
| out_len | output | LEN_W | Length of the head entry |
| out_data | output | DATA_W | Payload, or SYNC_WORD in a pattern frame |
| out_new_frame | output | 1 | Head entry must start a fresh frame at bit 0 |
| buf_full | output | 1 | Buffer in full (header-only) mode |
| buf_overflow | output | 1 | Sticky overflow status |
| buf_fill | output | AW+1 | Number of stored entries |

## Verification
The assertions assume that the packer never pops during a pattern frame, because the block ignores out_ready then, and that cmd_synch and cmd_fe_reset are sampled only after the internal reset has been released. The bench holds cmd_fe_reset high through the reset release, so that the first active edge performs a counter reload. After that it issues commands only as whole cycles, driven at the falling edge. Its stimulus covers mixed veto and header-only traffic, a long stall with out_ready low that reaches full mode and then drops crossings, synch bursts of one and of several cycles, and a run long enough to wrap the crossing counter.

// File: rtl/fesb_pkg.sv
package fesb_pkg;
  typedef enum logic {
    FRAME_DATA = 1'b0,
    FRAME_SYNC = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/fesb_fifo.sv
module fesb_fifo #(
  parameter int W  = 52,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [AW:0]   fill,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [W-1:0] mem [DEPTH];
  logic         wr_go, rd_go;

  assign full    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign empty   = (wptr_q == rptr_q);
  assign fill    = wptr_q - rptr_q;
  assign rd_data = mem[rptr_q[AW-1:0]];
  assign wr_go   = wr_en && !full && !clr;
  assign rd_go   = rd_en && !empty && !clr;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (wr_go) wptr_d = wptr_q + 1'b1;
      if (rd_go) rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr_q[AW-1:0]] <= wr_data;
  end
endmodule

// File: rtl/fesb_bx_counter.sv
module fesb_bx_counter #(
  parameter int BXID_W    = 12,
  parameter int BX_LAST   = 3563,
  parameter int BX_RELOAD = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              reload,
  output logic [BXID_W-1:0] bx
);
  localparam logic [BXID_W-1:0] LAST_V   = BXID_W'(BX_LAST);
  localparam logic [BXID_W-1:0] RELOAD_V = BXID_W'(BX_RELOAD);

  logic [BXID_W-1:0] bx_q, bx_d;

  always_comb begin
    if (reload)              bx_d = RELOAD_V;
    else if (bx_q == LAST_V) bx_d = '0;
    else                     bx_d = bx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) bx_q <= '0;
    else         bx_q <= bx_d;
  end

  assign bx = bx_q;
endmodule

// File: rtl/fe_sync_buffer_ctrl.sv
module fe_sync_buffer_ctrl #(
  parameter int               BXID_W      = 12,
  parameter int               LEN_W       = 8,
  parameter int               DATA_W      = 32,
  parameter int               AW          = 8,
  parameter int               HDR_RESERVE = 16,
  parameter int               BX_LAST     = 3563,
  parameter int               BX_RELOAD   = 16,
  parameter logic [DATA_W-1:0] SYNC_WORD  = 32'h5A5A_C3C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_synch,
  input  logic              cmd_fe_reset,
  input  logic              cmd_bx_veto,
  input  logic              cmd_hdr_only,
  input  logic              ev_valid,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_kind,
  output logic [BXID_W-1:0] out_bxid,
  output logic [LEN_W-1:0]  out_len,
  output logic [DATA_W-1:0] out_data,
  output logic              out_new_frame,
  output logic              buf_full,
  output logic              buf_overflow,
  output logic [AW:0]       buf_fill
);
  import fesb_pkg::*;

  localparam int          ENTRY_W = BXID_W + LEN_W + DATA_W;
  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] THRESH  = (AW+1)'(DEPTH - HDR_RESERVE);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // crossing counter
  logic [BXID_W-1:0] bx;
  fesb_bx_counter #(
    .BXID_W(BXID_W), .BX_LAST(BX_LAST), .BX_RELOAD(BX_RELOAD)
  ) i_bx (
    .clk(clk), .rst_ni(rst_ni), .reload(cmd_fe_reset), .bx(bx)
  );

  // write side
  logic               clr, hdr_cmd, throttle, keep_data, pop;
  logic               fifo_full, fifo_empty, ovf_set;
  logic [AW:0]        fill;
  logic [ENTRY_W-1:0] wr_entry, head;
  logic               sync_q, sync_d, restart_q, restart_d, ovf_q, ovf_d;
  logic [BXID_W-1:0]  sbx_q, sbx_d;

  assign clr       = cmd_synch | cmd_fe_reset;
  assign hdr_cmd   = cmd_bx_veto | cmd_hdr_only;
  assign throttle  = (fill >= THRESH);
  assign keep_data = ev_valid && !hdr_cmd && !throttle;
  assign wr_entry  = {bx,
                      keep_data ? ev_len  : {LEN_W{1'b0}},
                      keep_data ? ev_data : {DATA_W{1'b0}}};
  assign pop       = out_ready && !fifo_empty && !sync_q;
  assign ovf_set   = (ev_valid && !hdr_cmd && throttle) || fifo_full;

  fesb_fifo #(.W(ENTRY_W), .AW(AW)) i_fifo (
    .clk(clk), .rst_ni(rst_ni), .clr(clr),
    .wr_en(!clr), .wr_data(wr_entry),
    .rd_en(pop), .rd_data(head),
    .fill(fill), .full(fifo_full), .empty(fifo_empty)
  );

  // control next state
  always_comb begin
    sync_d    = 1'b0;
    sbx_d     = sbx_q;
    restart_d = restart_q;
    ovf_d     = ovf_q;
    if (cmd_fe_reset) begin
      restart_d = 1'b1;
      ovf_d     = 1'b0;
    end else if (cmd_synch) begin
      sync_d    = 1'b1;
      sbx_d     = bx;
      restart_d = 1'b1;
      ovf_d     = 1'b0;
    end else begin
      if (pop)     restart_d = 1'b0;
      if (ovf_set) ovf_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 1'b0;
      sbx_q     <= '0;
      restart_q <= 1'b1;
      ovf_q     <= 1'b0;
    end else begin
      sync_q    <= sync_d;
      sbx_q     <= sbx_d;
      restart_q <= restart_d;
      ovf_q     <= ovf_d;
    end
  end

  // output stream
  frame_kind_e kind;
  assign kind          = sync_q ? FRAME_SYNC : FRAME_DATA;
  assign out_kind      = kind;
  assign out_valid     = sync_q | !fifo_empty;
  assign out_bxid      = sync_q ? sbx_q : head[ENTRY_W-1 -: BXID_W];
  assign out_len       = sync_q ? {LEN_W{1'b0}} : head[DATA_W +: LEN_W];
  assign out_data      = sync_q ? SYNC_WORD : head[DATA_W-1:0];
  assign out_new_frame = restart_q && !sync_q && !fifo_empty;
  assign buf_full      = throttle;
  assign buf_overflow  = ovf_q;
  assign buf_fill      = fill;
endmodule

// File: rtl/fesb_checker.sv
module fesb_checker #(
  parameter int BXID_W = 12,
  parameter int DATA_W = 32,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              cmd_synch,
  input logic              cmd_fe_reset,
  input logic              cmd_bx_veto,
  input logic              cmd_hdr_only,
  input logic              ev_valid,
  input logic              out_ready,
  input logic              out_valid,
  input logic              out_kind,
  input logic [BXID_W-1:0] out_bxid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_new_frame,
  input logic              buf_full,
  input logic              buf_overflow,
  input logic [AW:0]       buf_fill
);
  localparam int DEPTH = 1 << AW;

  assert_head_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_kind && !out_ready && !cmd_synch && !cmd_fe_reset)
      |=> (out_valid && $stable(out_bxid) && $stable(out_data)));

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    buf_fill <= (AW+1)'(DEPTH));

  assert_full_sets_ovf_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (buf_full && ev_valid && !cmd_bx_veto && !cmd_hdr_only && !cmd_synch && !cmd_fe_reset)
      |=> buf_overflow);

  assert_synch_empties_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_synch |=> (buf_fill == '0));

  assert_pattern_frame_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_synch && !cmd_fe_reset) |=> (out_valid && out_kind));

  assert_new_frame_data_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    out_new_frame |-> (out_valid && !out_kind));

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_fe_reset |=> (!out_valid && !buf_overflow));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (buf_overflow && !cmd_synch && !cmd_fe_reset) |=> buf_overflow);
endmodule

bind fe_sync_buffer_ctrl fesb_checker #(
  .BXID_W(BXID_W), .DATA_W(DATA_W), .AW(AW)
) i_fesb_checker (
  .clk(clk), .rst_ni(rst_ni),
  .cmd_synch(cmd_synch), .cmd_fe_reset(cmd_fe_reset),
  .cmd_bx_veto(cmd_bx_veto), .cmd_hdr_only(cmd_hdr_only),
  .ev_valid(ev_valid), .out_ready(out_ready),
  .out_valid(out_valid), .out_kind(out_kind), .out_bxid(out_bxid),
  .out_data(out_data), .out_new_frame(out_new_frame),
  .buf_full(buf_full), .buf_overflow(buf_overflow), .buf_fill(buf_fill)
);

// File: tb/test_fe_sync_buffer_ctrl.sv
module test_fe_sync_buffer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BXID_W = 12, LEN_W = 8, DATA_W = 32, AW = 8;
  localparam int DEPTH = 256, THRESH = 240, BX_LAST = 3563, BX_RELOAD = 16;
  localparam logic [DATA_W-1:0] SYNC_W = 32'h5A5A_C3C3;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_synch, cmd_fe_reset, cmd_bx_veto, cmd_hdr_only, ev_valid, out_ready;
  logic [LEN_W-1:0] ev_len;
  logic [DATA_W-1:0] ev_data;
  logic out_valid, out_kind, out_new_frame, buf_full, buf_overflow;
  logic [BXID_W-1:0] out_bxid;
  logic [LEN_W-1:0] out_len;
  logic [DATA_W-1:0] out_data;
  logic [AW:0] buf_fill;

  always #(CLK_PERIOD/2) clk = ~clk;

  fe_sync_buffer_ctrl i_fe_sync_buffer_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_synch(cmd_synch), .cmd_fe_reset(cmd_fe_reset),
    .cmd_bx_veto(cmd_bx_veto), .cmd_hdr_only(cmd_hdr_only),
    .ev_valid(ev_valid), .ev_len(ev_len), .ev_data(ev_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_kind(out_kind),
    .out_bxid(out_bxid), .out_len(out_len), .out_data(out_data),
    .out_new_frame(out_new_frame), .buf_full(buf_full),
    .buf_overflow(buf_overflow), .buf_fill(buf_fill)
  );

  typedef struct { int bx; int len; logic [DATA_W-1:0] data; } ent_t;
  ent_t q[$];
  int  m_bx = 0, m_sbx = 0;
  bit  m_sq = 0, m_restart = 1, m_ovf = 0;
  bit  prev_s = 0, prev_r = 0, prev2_r = 0;
  int  tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ev = m_sq || (q.size() > 0);
    chk(out_valid == ev, "R4 valid", out_valid, ev);
    if (m_sq) begin
      chk(out_kind == 1'b1, "R7 kind", out_kind, 1);
      chk(out_bxid == BXID_W'(m_sbx), "R7 bxid", out_bxid, m_sbx);
      chk(out_data == SYNC_W && out_len == 0, "R7 data", out_data, SYNC_W);
    end else if (q.size() > 0) begin
      chk(out_kind == 1'b0, "R4 kind", out_kind, 0);
      chk(out_bxid == BXID_W'(q[0].bx), "R2 bxid", out_bxid, q[0].bx);
      chk(out_len == LEN_W'(q[0].len), "R3 len", out_len, q[0].len);
      chk(out_data == q[0].data, "R3 data", out_data, q[0].data);
      if (prev2_r && !prev_r && !prev_s)
        chk(out_bxid == BXID_W'(BX_RELOAD), "R9 reload", out_bxid, BX_RELOAD);
    end
    chk(out_new_frame == (m_restart && !m_sq && q.size() > 0), "R8 new_frame",
        out_new_frame, m_restart && !m_sq && q.size() > 0);
    chk(buf_fill == (AW+1)'(q.size()), "R5 fill", buf_fill, q.size());
    chk(buf_full == (q.size() >= THRESH), "R5 full", buf_full, q.size() >= THRESH);
    chk(buf_overflow == m_ovf, "R10 overflow", buf_overflow, m_ovf);
    if (prev_s) chk(buf_fill == 0, "R6 flush", buf_fill, 0);
    if (prev_r) chk(buf_fill == 0 && !out_valid, "R9 clear", buf_fill, 0);
  endtask

  function automatic int nxt(input int b);
    return (b == BX_LAST) ? 0 : b + 1;
  endfunction

  task automatic model_step();
    bit pop = out_ready && q.size() > 0 && !m_sq;
    bit thr = q.size() >= THRESH;
    bit full = q.size() == DEPTH;
    bit hdr = cmd_bx_veto || cmd_hdr_only;
    prev2_r = prev_r;
    prev_r  = cmd_fe_reset;
    prev_s  = cmd_synch && !cmd_fe_reset;
    if (cmd_fe_reset) begin
      q.delete(); m_ovf = 0; m_bx = BX_RELOAD; m_sq = 0; m_restart = 1;
    end else if (cmd_synch) begin
      q.delete(); m_ovf = 0; m_sq = 1; m_sbx = m_bx; m_restart = 1; m_bx = nxt(m_bx);
    end else begin
      ent_t e;
      m_sq = 0;
      if (pop) begin void'(q.pop_front()); m_restart = 0; end
      if ((ev_valid && !hdr && thr) || full) m_ovf = 1;
      e.bx = m_bx;
      if (ev_valid && !hdr && !thr) begin e.len = int'(ev_len); e.data = ev_data; end
      else begin e.len = 0; e.data = '0; end
      if (!full) q.push_back(e);
      m_bx = nxt(m_bx);
    end
  endtask

  task automatic cyc(input bit s, input bit r, input bit v, input bit h,
                     input bit iv, input bit rdy);
    @(negedge clk);
    compare();
    cmd_synch = s; cmd_fe_reset = r; cmd_bx_veto = v; cmd_hdr_only = h;
    ev_valid = iv; ev_len = LEN_W'($urandom); ev_data = $urandom; out_ready = rdy;
    model_step();
  endtask

  task automatic traffic(input int n, input int rdy_pct);
    for (int i = 0; i < n; i++)
      cyc(0, 0, ($urandom % 8) == 0, ($urandom % 8) == 1, ($urandom % 4) != 0,
          ($urandom % 100) < rdy_pct);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_synch = 0; cmd_fe_reset = 1; cmd_bx_veto = 0; cmd_hdr_only = 0;
    ev_valid = 0; ev_len = '0; ev_data = '0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!out_valid, "R1 valid", out_valid, 0);
    chk(buf_fill == 0, "R1 fill", buf_fill, 0);
    chk(!buf_full && !buf_overflow, "R1 flags", {buf_full, buf_overflow}, 0);
    rst_n = 1;
    model_step(); // reset pulse held through the reset release edge
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    // R2 R3 R4 R8 mixed traffic
    traffic(400, 70);
    // R5 R10 stall to full mode and beyond
    for (int i = 0; i < 280; i++) cyc(0, 0, 0, 0, 1, 0);
    traffic(20, 0);
    // R6 R7 synch burst while the packer stalls
    cyc(1, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 1, 1);
    cyc(1, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 1, 0);
    traffic(60, 80);
    // R9 front-end reset
    cyc(0, 1, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 1, 0);
    traffic(50, 60);
    // R6 single synch in traffic, then long run to wrap the counter (R2)
    cyc(1, 0, 0, 0, 1, 1);
    traffic(3700, 75);
    for (int i = 0; i < 250; i++) cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, 0); // R9 priority over synch
    traffic(30, 90);
    @(negedge clk);
    compare();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule